// File: doc/BRIEF.md
# Majority-Vote Pattern Bank

The block is an associative memory for recognising hit patterns across eight detector layers. Every stored pattern is one row of eight layer words, and each word belongs to one of eight parallel input buses. On every clock, each input bus that carries a valid word is compared with the word for that layer in every stored pattern. A layer that compares equal sets a flag for that pattern, and the flag stays set until the event is cleared. So the hits of an event can arrive over several cycles and in any order.

A pattern counts as matched when the number of its set layer flags is at least a run-time threshold. When the end of an event is signalled, the block reports the addresses of all matched patterns in ascending order, one per cycle, and then raises a done indication. While this report is running, the flags are frozen and requests to clear or to end an event are ignored. Patterns are loaded through a plain address/layer/data write port. The number of patterns, the number of layers and the word width are parameters.

Top module: `amb_bank`

## Requirements
- R1: When `wr_en` is high at a clock edge, `wr_data` becomes the stored word of layer `wr_layer` in pattern `wr_addr`. Every later comparison on that layer uses the new word.
- R2: A layer flag of a pattern is set at a clock edge only when that layer's `bus_valid` bit is high and its bus word equals the stored word. A word whose valid bit is low has no effect, whatever its value.
- R3: A set layer flag stays set across later non-matching or invalid words. A pulse on `evt_clear` (outside a readout) clears every flag of every pattern at the next edge.
- R4: A pattern is matched when the number of its set flags is greater than or equal to the effective threshold. `cfg_we` loads `cfg_thresh` (3 bits). Codes 1 to 7 mean that count, and code 0 means 8.
- R5: An `evt_end` pulse outside a readout takes a snapshot of the matched set. From the next cycle on, `rd_valid` is high for exactly one cycle per matched pattern, with `rd_addr` giving the addresses in strictly ascending order and with no gaps.
- R6: `rd_done` is high for exactly one cycle, right after the last address, or in the first cycle after `evt_end` if nothing matched. It is never high together with `rd_valid`, and both are low afterwards.
- R7: During a readout, `evt_clear` and `evt_end` are ignored and no flag changes. A second `evt_end` without a clear reports the same address list again.
- R8: After reset, all flags and stored words are zero, the threshold code is 0 (meaning 8), and `rd_valid` and `rd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern word write strobe |
| wr_addr | input | 5 | Pattern address to write |
| wr_layer | input | 3 | Layer index to write |
| wr_data | input | 15 | Word to store |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_thresh | input | 3 | Threshold code (0 means 8) |
| evt_clear | input | 1 | Clear all layer flags |
| evt_end | input | 1 | End of event; start the readout |
| bus_valid | input | 8 | Per-layer word valid strobes |
| bus_data | input | 120 | Eight 15-bit layer words; layer n uses bits [15n+14:15n] |
| rd_valid | output | 1 | A matched address is on `rd_addr` |
| rd_addr | output | 5 | Matched pattern address |
| rd_done | output | 1 | Readout finished |

## Verification
The assertions assume that reset is held for at least one clock before any strobe, and that the strobes are clean single-cycle levels sampled at the rising edge. The ascending-address property also assumes that a readout is never restarted halfway through; the block itself ensures this by ignoring `evt_end` during a readout. The bench changes every input at the falling edge and reads outputs at the next falling edge. It sends `evt_clear` and `evt_end` during a readout only on purpose, to show that they are ignored. Lanes marked invalid still carry the words stored in pattern 0, so any use of an invalid word would show up as a false match.

// File: rtl/amb_pkg.sv
package amb_pkg;
   // Default geometry of one bank.
   localparam int AMB_LAYERS = 8;
   localparam int AMB_WORD_W = 15;
   localparam int AMB_PATT   = 32;
endpackage

// File: rtl/amb_layer_cell.sv
module amb_layer_cell #(
   parameter int WORD_W = amb_pkg::AMB_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              cmp_en,
   input  logic              clr,
   input  logic              bus_vld,
   input  logic [WORD_W-1:0] bus_word,
   output logic              flag
);
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= load_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                         flag <= 1'b0;
      else if (clr)                                       flag <= 1'b0;
      else if (cmp_en && bus_vld && (bus_word == word_q)) flag <= 1'b1;
   end

   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
   p_invalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !(cmp_en && bus_vld)) |=> !flag);
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !clr) |=> $stable(flag));
endmodule

// File: rtl/amb_pattern_row.sv
module amb_pattern_row #(
   parameter int LAYERS = amb_pkg::AMB_LAYERS,
   parameter int WORD_W = amb_pkg::AMB_WORD_W,
   localparam int CW    = $clog2(LAYERS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LAYERS-1:0]        load,
   input  logic [WORD_W-1:0]        load_word,
   input  logic                     cmp_en,
   input  logic                     clr,
   input  logic [LAYERS-1:0]        bus_vld,
   input  logic [LAYERS*WORD_W-1:0] bus_data,
   input  logic [CW-1:0]            thr_eff,
   output logic                     hit
);
   logic [LAYERS-1:0] flags;
   logic [CW-1:0]     count;

   for (genvar l = 0; l < LAYERS; l++) begin : g_cell
      amb_layer_cell #(.WORD_W(WORD_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load[l]),
         .load_word(load_word),
         .cmp_en   (cmp_en),
         .clr      (clr),
         .bus_vld  (bus_vld[l]),
         .bus_word (bus_data[l*WORD_W +: WORD_W]),
         .flag     (flags[l])
      );
   end

   always_comb begin
      count = '0;
      for (int l = 0; l < LAYERS; l++) count = count + CW'(flags[l]);
   end

   assign hit = (count >= thr_eff);
endmodule

// File: rtl/amb_scan.sv
module amb_scan #(
   parameter int NUM_PATT = amb_pkg::AMB_PATT,
   localparam int AW      = $clog2(NUM_PATT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_PATT-1:0] hits,
   output logic                rd_valid,
   output logic [AW-1:0]       rd_addr,
   output logic                rd_done,
   output logic                active
);
   logic [NUM_PATT-1:0] pend_q;
   logic                act_q;
   logic [AW-1:0]       low_idx;
   logic                found;

   always_comb begin
      low_idx = '0;
      for (int i = NUM_PATT - 1; i >= 0; i--)
         if (pend_q[i]) low_idx = AW'(i);
      found = |pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         pend_q <= '0;
      end else if (!act_q) begin
         if (start) begin
            act_q  <= 1'b1;
            pend_q <= hits;
         end
      end else if (found) begin
         pend_q[low_idx] <= 1'b0;
      end else begin
         act_q <= 1'b0;
      end
   end

   assign rd_valid = act_q && found;
   assign rd_done  = act_q && !found;
   assign rd_addr  = low_idx;
   assign active   = act_q;

   p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid)) |-> (rd_addr > $past(rd_addr)));
   p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> (!rd_valid && !rd_done));
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !rd_done) |=> active);
endmodule

// File: rtl/amb_bank.sv
module amb_bank #(
   parameter int LAYERS   = amb_pkg::AMB_LAYERS,
   parameter int WORD_W   = amb_pkg::AMB_WORD_W,
   parameter int NUM_PATT = amb_pkg::AMB_PATT,
   localparam int AW      = $clog2(NUM_PATT),
   localparam int LW      = $clog2(LAYERS),
   localparam int CW      = $clog2(LAYERS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [LW-1:0]            wr_layer,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic                     cfg_we,
   input  logic [LW-1:0]            cfg_thresh,
   input  logic                     evt_clear,
   input  logic                     evt_end,
   input  logic [LAYERS-1:0]        bus_valid,
   input  logic [LAYERS*WORD_W-1:0] bus_data,
   output logic                     rd_valid,
   output logic [AW-1:0]            rd_addr,
   output logic                     rd_done
);
   if (LAYERS < 2 || (1 << LW) != LAYERS) begin : g_bad_layers
      $error("amb_bank: LAYERS must be a power of two, at least 2");
   end
   if (NUM_PATT < 2 || WORD_W < 1) begin : g_bad_geom
      $error("amb_bank: NUM_PATT must be at least 2 and WORD_W at least 1");
   end

   logic [LW-1:0]       thr_q;
   logic [CW-1:0]       thr_eff;
   logic [NUM_PATT-1:0] hits;
   logic                scan_act;
   logic                cmp_en;
   logic                clr;

   always_ff @(posedge clk) begin
      if (!rst_n)      thr_q <= '0;
      else if (cfg_we) thr_q <= cfg_thresh;
   end

   assign thr_eff = (thr_q == '0) ? CW'(LAYERS) : CW'(thr_q);
   assign cmp_en  = !scan_act;
   assign clr     = evt_clear && !scan_act;

   for (genvar p = 0; p < NUM_PATT; p++) begin : g_row
      logic [LAYERS-1:0] row_load;
      for (genvar l = 0; l < LAYERS; l++) begin : g_ld
         assign row_load[l] = wr_en && (wr_addr == AW'(p)) && (wr_layer == LW'(l));
      end
      amb_pattern_row #(.LAYERS(LAYERS), .WORD_W(WORD_W)) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (row_load),
         .load_word(wr_data),
         .cmp_en   (cmp_en),
         .clr      (clr),
         .bus_vld  (bus_valid),
         .bus_data (bus_data),
         .thr_eff  (thr_eff),
         .hit      (hits[p])
      );
   end

   amb_scan #(.NUM_PATT(NUM_PATT)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (evt_end),
      .hits    (hits),
      .rd_valid(rd_valid),
      .rd_addr (rd_addr),
      .rd_done (rd_done),
      .active  (scan_act)
   );

   p_thr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_eff >= CW'(1)) && (thr_eff <= CW'(LAYERS)));
   p_scan_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_done) |=> $stable(thr_eff) || $past(cfg_we));
endmodule

// File: tb/amb_bank_bench.sv
`timescale 1ns/1ps
module amb_bank_bench;
   localparam int L  = 8;
   localparam int WW = 15;
   localparam int NP = 32;
   localparam int AW = 5;
   localparam logic [5:0] N = 6'd63;

   typedef struct packed {
      logic [2:0]      thr;
      logic [7:0][5:0] ia;
      logic [7:0][5:0] ib;
      logic [5:0]      nhit;
   } vec_t;

   // Pattern index per layer (layer 7 leftmost), 63 = lane invalid.
   localparam vec_t VECS [7] = '{
      '{thr:3'd0, ia:{8{6'd5}}, ib:{8{N}}, nhit:6'd1},
      '{thr:3'd4, ia:{6'd9,6'd9,6'd9,6'd9,6'd7,6'd7,6'd7,6'd7}, ib:{8{N}}, nhit:6'd2},
      '{thr:3'd3, ia:{N,N,N,6'd10,N,6'd2,6'd2,6'd2}, ib:{N,N,N,6'd11,6'd2,N,N,N}, nhit:6'd1},
      '{thr:3'd1, ia:{N,N,N,N,N,6'd16,6'd31,6'd0}, ib:{8{N}}, nhit:6'd3},
      '{thr:3'd2, ia:{N,N,N,N,N,N,6'd6,6'd4}, ib:{8{N}}, nhit:6'd0},
      '{thr:3'd7, ia:{6'd13,{7{6'd12}}}, ib:{8{N}}, nhit:6'd1},
      '{thr:3'd0, ia:{6'd13,{7{6'd12}}}, ib:{8{N}}, nhit:6'd0}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic wr_en, cfg_we, evt_clear, evt_end;
   logic [AW-1:0] wr_addr;
   logic [2:0] wr_layer, cfg_thresh;
   logic [WW-1:0] wr_data;
   logic [L-1:0] bus_valid;
   logic [L-1:0][WW-1:0] bus_data;
   logic rd_valid, rd_done;
   logic [AW-1:0] rd_addr;

   int nchk = 0;
   int nbad = 0;
   bit ended = 0;
   logic [WW-1:0] mem_m [NP][L];
   int exp_addr [NP];
   int exp_n;

   always #2.5 clk = ~clk;

   amb_bank u_amb_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_layer(wr_layer), .wr_data(wr_data), .cfg_we(cfg_we),
      .cfg_thresh(cfg_thresh), .evt_clear(evt_clear), .evt_end(evt_end),
      .bus_valid(bus_valid), .bus_data(bus_data), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_done(rd_done)
   );

   function automatic logic [WW-1:0] wgen(int p, int l);
      return WW'((((p * 8 + l) * 613) + 77) % 32768);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic mk_beat(input logic [7:0][5:0] ix, output logic [7:0] v,
                          output logic [7:0][WW-1:0] w);
      for (int l = 0; l < L; l++) begin
         v[l] = (ix[l] != N);
         w[l] = (ix[l] != N) ? wgen(int'(ix[l]), l) : wgen(0, l);
      end
   endtask

   task automatic model(input logic [2:0] thr, input logic [7:0] va,
                        input logic [7:0][WW-1:0] wa, input logic [7:0] vb,
                        input logic [7:0][WW-1:0] wb);
      int te;
      te = (thr == 0) ? 8 : int'(thr);
      exp_n = 0;
      for (int p = 0; p < NP; p++) begin
         int cnt;
         cnt = 0;
         for (int l = 0; l < L; l++)
            if ((va[l] && wa[l] == mem_m[p][l]) || (vb[l] && wb[l] == mem_m[p][l])) cnt++;
         if (cnt >= te) begin
            exp_addr[exp_n] = p;
            exp_n++;
         end
      end
   endtask

   task automatic readout(input bit poke, input string tag);
      int idx;
      bit done;
      idx = 0;
      done = 0;
      @(negedge clk) evt_end = 1'b1;
      @(negedge clk) evt_end = 1'b0;
      for (int c = 0; c < NP + 4 && !done; c++) begin
         if (c > 0) @(negedge clk);
         check(!(rd_valid && rd_done), {"R6 exclusive ", tag}, int'(rd_done), 0);
         if (rd_valid) begin
            check(idx < exp_n && int'(rd_addr) == exp_addr[idx], {"R5 address ", tag},
                  int'(rd_addr), (idx < exp_n) ? exp_addr[idx] : -1);
            idx++;
         end else if (rd_done) begin
            done = 1;
         end else begin
            check(0, {"R6 gap ", tag}, 0, 1);
         end
         if (poke) begin
            evt_clear = (c == 0);
            evt_end   = (c == 0);
         end
      end
      evt_clear = 1'b0;
      evt_end   = 1'b0;
      check(done, {"R6 done seen ", tag}, int'(done), 1);
      check(idx == exp_n, {"R5 count ", tag}, idx, exp_n);
      @(negedge clk);
      check(!rd_done && !rd_valid, {"R6 idle after ", tag}, int'(rd_done | rd_valid), 0);
   endtask

   task automatic run_event(input logic [2:0] thr, input logic [7:0] va,
                            input logic [7:0][WW-1:0] wa, input logic [7:0] vb,
                            input logic [7:0][WW-1:0] wb, input bit poke, input string tag);
      model(thr, va, wa, vb, wb);
      @(negedge clk);
      cfg_we = 1'b1; cfg_thresh = thr; evt_clear = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; evt_clear = 1'b0; bus_valid = va; bus_data = wa;
      @(negedge clk);
      bus_valid = vb; bus_data = wb;
      @(negedge clk);
      bus_valid = '0;
      readout(poke, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
      end
      $finish;
   end

   initial begin
      logic [7:0] va, vb;
      logic [7:0][WW-1:0] wa, wb;
      rst_n = 1'b0; wr_en = 1'b0; cfg_we = 1'b0; evt_clear = 1'b0; evt_end = 1'b0;
      wr_addr = '0; wr_layer = '0; wr_data = '0; cfg_thresh = '0;
      bus_valid = '0; bus_data = '0;
      repeat (3) @(negedge clk);
      check(!rd_valid && !rd_done, "R8 outputs in reset", int'(rd_valid | rd_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rd_valid && !rd_done, "R8 outputs after reset", int'(rd_valid | rd_done), 0);

      // R8: fresh bank, threshold 8, all flags clear -> empty readout
      exp_n = 0;
      readout(0, "R8 empty");

      // R1: load every word
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < L; l++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(p); wr_layer = 3'(l); wr_data = wgen(p, l);
            mem_m[p][l] = wgen(p, l);
         end
      @(negedge clk) wr_en = 1'b0;

      // R2 R3 R4 R5: table of events
      foreach (VECS[i]) begin
         mk_beat(VECS[i].ia, va, wa);
         mk_beat(VECS[i].ib, vb, wb);
         run_event(VECS[i].thr, va, wa, vb, wb, 0, $sformatf("R4 vec%0d", i));
         check(exp_n == int'(VECS[i].nhit), $sformatf("R4 R2 table vec%0d", i),
               exp_n, int'(VECS[i].nhit));
      end

      // R7: clear and end during readout are ignored; list repeats
      mk_beat(VECS[3].ia, va, wa);
      mk_beat(VECS[3].ib, vb, wb);
      run_event(3'd1, va, wa, vb, wb, 1, "R7 poke");
      readout(0, "R7 repeat");

      // R3: clear empties every flag
      @(negedge clk) evt_clear = 1'b1;
      @(negedge clk) evt_clear = 1'b0;
      exp_n = 0;
      readout(0, "R3 cleared");

      // R1: overwrite one word, old word no longer matches
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd20; wr_layer = 3'd3; wr_data = 15'h7abc;
      mem_m[20][3] = 15'h7abc;
      @(negedge clk) wr_en = 1'b0;
      for (int l = 0; l < L; l++) begin wa[l] = wgen(0, l); wb[l] = wgen(0, l); end
      wa[3] = 15'h7abc;
      wb[3] = wgen(20, 3);
      run_event(3'd1, 8'h08, wa, 8'h08, wb, 0, "R1 rewrite");
      check(exp_n == 1 && exp_addr[0] == 20, "R1 model", exp_n, 1);

      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
      end
      $finish;
   end
endmodule